// File: doc/BRIEF.md
# Port-Control Microsequencer

This block is a small programmable engine that drives a byte-wide port register set (data, status, control) without software involvement for each bus access. A program of 32-bit microinstructions is written into a local instruction store through a write port. A one-cycle `start` pulse begins execution at address 0. The block then reads and writes the port registers, waits for a number of microseconds, loops, branches on status bits, calls one level of subroutine and exchanges bytes with an external buffer memory. It stops when it reaches a return instruction. At that point it raises `done` for one cycle and presents the return code.

The execution context has five parts: a program counter, a loop register used by the decrement-and-branch instruction, a byte pointer into the buffer, a single saved return address and an in-subroutine flag. A `start` pulse clears the loop register, the pointer and the subroutine flag. Relative branches add a signed 8-bit offset to the address of the following instruction, wrapping modulo the store depth. The port register interface and the buffer memory both return read data in the same cycle as the request.

Each microinstruction has these fields: opcode in bits 31:28, register select in bits 27:26, reserved bits 25:24 (must be 0), operand A in bits 23:16, operand B in bits 15:8 and operand C in bits 7:0. The status register is register select 1.

Top module: `port_useq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `reg_rd`, `reg_wr` and `buf_we` are 0 and `ret_code` is 0.
- R2: A `start` pulse while idle begins execution at address 0. Opcode 9 ends the program: `done` is high for exactly one cycle, `ret_code` takes C, and `busy` is low from that cycle on.
- R3: Opcode 0 reads the selected register and writes back (old AND NOT B) OR A in the same cycle, so a bit present in both masks ends up set.
- R4: Opcode 1 writes A to the selected register. Opcode 2 stores (selected register AND A) into buffer address C.
- R5: Opcode 3 with C = N holds the program for N microseconds: it occupies 1 + N*(CLK_HZ/1e6) cycles, and N = 0 occupies one cycle.
- R6: Opcode 4 loads the loop register with {A,C}. Opcode 5 decrements it and branches to (next address + signed C) only when the decremented value is positive as a signed number.
- R7: Opcode 6 branches when any status bit selected by A is 1. Opcode 7 branches when any status bit selected by A is 0. Both use the target rule of R6.
- R8: Opcode 8 branches only when every status bit in A is 1 and every status bit in B is 0.
- R9: Opcode 10 jumps to absolute address C and saves the next address. Opcode 11 resumes at the saved address.
- R10: The following stop the program with `done` and `ret_code` = ERR_RC (default 0xFF): a call made inside a subroutine, opcode 11 outside a subroutine, opcode 15, or nonzero reserved bits.
- R11: Opcode 12 loads the buffer pointer with C. Opcode 13 writes C bytes from the buffer at the pointer to the selected register. Opcode 14 stores C bytes of (selected register AND A) at the pointer. Each byte advances the pointer by one, and C = 0 moves nothing.
- R12: A `start` pulse while the program runs is ignored: the sequence of register writes and the single `done` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | AW | Instruction store write address |
| prog_data | input | 32 | Instruction word to store |
| start | input | 1 | Begin execution at address 0 |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| ret_code | output | 8 | Code from the last return or error |
| reg_sel | output | 2 | Port register select |
| reg_rd | output | 1 | Port register read strobe |
| reg_wr | output | 1 | Port register write strobe |
| reg_wdata | output | 8 | Port register write data |
| reg_rdata | input | 8 | Port register read data, same cycle |
| buf_addr | output | 8 | Buffer memory address |
| buf_we | output | 1 | Buffer memory write enable |
| buf_wdata | output | 8 | Buffer memory write data |
| buf_rdata | input | 8 | Buffer memory read data, same cycle |

## Verification
The assertions assume three things about the surroundings. `reg_rdata` and `buf_rdata` reflect the currently addressed location in the same cycle. The instruction store is not rewritten while a program runs. `start` is a level sampled on the clock. The bench meets these assumptions with combinational register and buffer models, loads every program before pulsing `start`, and drives all inputs on the falling edge, so that each sample sees settled values.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [3:0] {
        OP_RMOD  = 4'd0,
        OP_RPUT  = 4'd1,
        OP_RGET  = 4'd2,
        OP_WAIT  = 4'd3,
        OP_LDCNT = 4'd4,
        OP_DECBR = 4'd5,
        OP_BANY1 = 4'd6,
        OP_BANY0 = 4'd7,
        OP_BALL  = 4'd8,
        OP_END   = 4'd9,
        OP_CALL  = 4'd10,
        OP_SRET  = 4'd11,
        OP_LDPTR = 4'd12,
        OP_PUTP  = 4'd13,
        OP_GETP  = 4'd14
    } op_e;

    typedef struct packed {
        logic [3:0] op;
        logic [1:0] rsel;
        logic [1:0] rsvd;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] c;
    } uins_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_WAIT = 2'd2,
        S_MOVE = 2'd3
    } st_e;

    localparam logic [1:0] STAT_SEL = 2'd1;

endpackage

// File: rtl/useq_imem.sv
module useq_imem #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/useq_delay.sv
module useq_delay #(
    parameter int CYC_PER_US = 125,
    localparam int PW = $clog2(CYC_PER_US + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] us,
    output logic       fin
);
    typedef struct packed {
        logic [PW-1:0] pre;
        logic [7:0]    left;
    } dly_t;

    dly_t q, d;

    localparam logic [PW-1:0] PRE_TOP = PW'(CYC_PER_US - 1);

    assign fin = (q.left == 8'd1) && (q.pre == '0);

    always_comb begin
        d = q;
        if (load) begin
            d.left = us;
            d.pre  = PRE_TOP;
        end else if (q.left != 8'd0) begin
            if (q.pre == '0) begin
                d.pre  = PRE_TOP;
                d.left = q.left - 8'd1;
            end else begin
                d.pre = q.pre - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    dly_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !load) |=> (q.left == 8'd0));
endmodule

// File: rtl/useq_cond.sv
module useq_cond
    import useq_pkg::*;
(
    input  logic [3:0] op,
    input  logic [7:0] stat,
    input  logic [7:0] mask_hi,
    input  logic [7:0] mask_lo,
    output logic       take
);
    always_comb begin
        case (op)
            OP_BANY1: take = |(stat & mask_hi);
            OP_BANY0: take = |(~stat & mask_hi);
            OP_BALL:  take = ((stat & mask_hi) == mask_hi) && ((stat & mask_lo) == 8'd0);
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/port_useq.sv
module port_useq
    import useq_pkg::*;
#(
    parameter int          IMEM_DEPTH = 32,
    parameter int unsigned CLK_HZ     = 125_000_000,
    parameter int          BR_W       = 16,
    parameter logic [7:0]  ERR_RC     = 8'hFF,
    localparam int AW  = $clog2(IMEM_DEPTH),
    localparam int CYC = (CLK_HZ >= 1_000_000) ? int'(CLK_HZ / 1_000_000) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [31:0]   prog_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [7:0]    ret_code,
    output logic [1:0]    reg_sel,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [7:0]    reg_wdata,
    input  logic [7:0]    reg_rdata,
    output logic [7:0]    buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    input  logic [7:0]    buf_rdata
);
    typedef struct packed {
        st_e             st;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   ret_pc;
        logic            in_sub;
        logic [BR_W-1:0] br;
        logic [7:0]      ptr;
        logic [7:0]      cnt;
        logic            done;
        logic [7:0]      rc;
    } ctx_t;

    ctx_t q, d;

    logic [31:0]     imem_rdata;
    uins_t           ins;
    logic            take;
    logic            dly_load;
    logic            dly_fin;
    logic [AW-1:0]   nxt_pc;
    logic [AW-1:0]   tgt_pc;
    logic [BR_W-1:0] br_dec;
    logic            fault;

    useq_imem #(.DEPTH(IMEM_DEPTH), .AW(AW)) u_imem (
        .clk  (clk),
        .we   (prog_we),
        .waddr(prog_addr),
        .wdata(prog_data),
        .raddr(q.pc),
        .rdata(imem_rdata)
    );

    useq_delay #(.CYC_PER_US(CYC)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .load (dly_load),
        .us   (ins.c),
        .fin  (dly_fin)
    );

    useq_cond u_cond (
        .op     (ins.op),
        .stat   (reg_rdata),
        .mask_hi(ins.a),
        .mask_lo(ins.b),
        .take   (take)
    );

    assign ins    = uins_t'(imem_rdata);
    assign nxt_pc = q.pc + 1'b1;
    assign tgt_pc = nxt_pc + AW'(signed'(ins.c));
    assign br_dec = q.br - 1'b1;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        reg_sel   = ins.rsel;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = 8'd0;
        buf_addr  = q.ptr;
        buf_we    = 1'b0;
        buf_wdata = 8'd0;
        dly_load  = 1'b0;
        fault     = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st     = S_EXEC;
                    d.pc     = '0;
                    d.br     = '0;
                    d.ptr    = 8'd0;
                    d.in_sub = 1'b0;
                end
            end
            S_EXEC: begin
                if (ins.rsvd != 2'd0) begin
                    fault = 1'b1;
                end else begin
                    case (ins.op)
                        OP_RMOD: begin
                            reg_rd    = 1'b1;
                            reg_wr    = 1'b1;
                            reg_wdata = (reg_rdata & ~ins.b) | ins.a;
                            d.pc      = nxt_pc;
                        end
                        OP_RPUT: begin
                            reg_wr    = 1'b1;
                            reg_wdata = ins.a;
                            d.pc      = nxt_pc;
                        end
                        OP_RGET: begin
                            reg_rd    = 1'b1;
                            buf_addr  = ins.c;
                            buf_we    = 1'b1;
                            buf_wdata = reg_rdata & ins.a;
                            d.pc      = nxt_pc;
                        end
                        OP_WAIT: begin
                            if (ins.c == 8'd0) begin
                                d.pc = nxt_pc;
                            end else begin
                                dly_load = 1'b1;
                                d.st     = S_WAIT;
                            end
                        end
                        OP_LDCNT: begin
                            d.br = BR_W'({ins.a, ins.c});
                            d.pc = nxt_pc;
                        end
                        OP_DECBR: begin
                            d.br = br_dec;
                            d.pc = (!br_dec[BR_W-1] && br_dec != '0) ? tgt_pc : nxt_pc;
                        end
                        OP_BANY1, OP_BANY0, OP_BALL: begin
                            reg_sel = STAT_SEL;
                            reg_rd  = 1'b1;
                            d.pc    = take ? tgt_pc : nxt_pc;
                        end
                        OP_END: begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                            d.rc   = ins.c;
                        end
                        OP_CALL: begin
                            if (q.in_sub) begin
                                fault = 1'b1;
                            end else begin
                                d.in_sub = 1'b1;
                                d.ret_pc = nxt_pc;
                                d.pc     = AW'(ins.c);
                            end
                        end
                        OP_SRET: begin
                            if (!q.in_sub) begin
                                fault = 1'b1;
                            end else begin
                                d.in_sub = 1'b0;
                                d.pc     = q.ret_pc;
                            end
                        end
                        OP_LDPTR: begin
                            d.ptr = ins.c;
                            d.pc  = nxt_pc;
                        end
                        OP_PUTP, OP_GETP: begin
                            if (ins.c == 8'd0) begin
                                d.pc = nxt_pc;
                            end else begin
                                d.cnt = ins.c;
                                d.st  = S_MOVE;
                            end
                        end
                        default: fault = 1'b1;
                    endcase
                end
                if (fault) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                    d.rc   = ERR_RC;
                end
            end
            S_WAIT: begin
                if (dly_fin) begin
                    d.pc = nxt_pc;
                    d.st = S_EXEC;
                end
            end
            S_MOVE: begin
                if (ins.op == OP_PUTP) begin
                    reg_wr    = 1'b1;
                    reg_wdata = buf_rdata;
                end else begin
                    reg_rd    = 1'b1;
                    buf_we    = 1'b1;
                    buf_wdata = reg_rdata & ins.a;
                end
                d.ptr = q.ptr + 8'd1;
                d.cnt = q.cnt - 8'd1;
                if (q.cnt == 8'd1) begin
                    d.pc = nxt_pc;
                    d.st = S_EXEC;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign ret_code = q.rc;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_wr && !buf_we && !reg_rd));

    // R11
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_MOVE) |=> (q.ptr == $past(q.ptr) + 8'd1));

    // R10
    nest_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_EXEC && ins.rsvd == 2'd0 && ins.op == OP_CALL && q.in_sub)
        |=> (done && ret_code == ERR_RC));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAIT && !dly_fin) |=> (q.st == S_WAIT && $stable(q.pc)));
endmodule

// File: tb/port_useq_test.sv
module port_useq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_we = 1'b0;
    logic [4:0] prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic       start = 1'b0;
    logic       busy, done;
    logic [7:0] ret_code;
    logic [1:0] reg_sel;
    logic       reg_rd, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] buf_addr;
    logic       buf_we;
    logic [7:0] buf_wdata, buf_rdata;

    logic [7:0] regs [4];
    logic [7:0] bmem [256];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int done_cnt = 0;
    logic [7:0] last_rc = 8'd0;
    int wr_cyc [$];
    logic [9:0] exp_q [$];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    port_useq #(.IMEM_DEPTH(32), .CLK_HZ(125_000_000)) uut (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .start(start), .busy(busy), .done(done),
        .ret_code(ret_code), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_addr(buf_addr),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    assign reg_rdata = regs[reg_sel];
    assign buf_rdata = bmem[buf_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (reg_wr) regs[reg_sel] <= reg_wdata;
        if (buf_we) bmem[buf_addr] <= buf_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: compares every register write against the queue
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            wr_cyc.push_back(cyc);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected register write", {22'd0, reg_sel, reg_wdata}, 32'h0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({reg_sel, reg_wdata} == e, "R3", "register write", {22'd0, reg_sel, reg_wdata}, {22'd0, e});
            end
        end
        if (rst_n && done) begin
            done_cnt++;
            last_rc = ret_code;
        end
    end

    function automatic logic [31:0] mk(input int op, input int rs, input int a, input int b, input int c);
        return {op[3:0], rs[1:0], 2'b00, a[7:0], b[7:0], c[7:0]};
    endfunction

    task automatic expect_wr(input int sel, input int data);
        exp_q.push_back({sel[1:0], data[7:0]});
    endtask

    task automatic ld(input int addr, input logic [31:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = addr[4:0]; prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input logic [7:0] exp_rc, input string req);
        int base;
        base = done_cnt;
        for (int i = 0; i < 3000 && done_cnt == base; i++) @(negedge clk);
        chk(done_cnt == base + 1, req, "done count", done_cnt - base, 1);
        chk(last_rc == exp_rc, req, "return code", last_rc, exp_rc);
        @(negedge clk);
        chk(!done && !busy, "R2", "done single pulse and idle", {done, busy}, 0);
        chk(exp_q.size() == 0, req, "pending expected writes", exp_q.size(), 0);
    endtask

    task automatic run(input logic [7:0] exp_rc, input string req);
        wr_cyc.delete();
        pulse_start();
        wait_done(exp_rc, req);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            chk(1'b0, "R2", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) regs[i] = 8'd0;
        for (int i = 0; i < 256; i++) bmem[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && ret_code == 8'd0 && !reg_wr && !reg_rd && !buf_we,
            "R1", "reset state", {busy, done, reg_wr, reg_rd, buf_we, ret_code}, 0);

        // R3 R4: modify with overlapping masks, put, fetch
        regs[2] = 8'hF0;
        ld(0, mk(0, 2, 8'h05, 8'h31, 0));
        ld(1, mk(1, 0, 8'h5A, 0, 0));
        ld(2, mk(2, 2, 8'h0F, 0, 8'h10));
        ld(3, mk(9, 0, 0, 0, 8'h21));
        expect_wr(2, 8'hC5);
        expect_wr(0, 8'h5A);
        run(8'h21, "R2");
        chk(bmem[8'h10] == 8'h05, "R4", "fetch into buffer", bmem[8'h10], 8'h05);

        // R6 counted loop
        ld(0, mk(4, 0, 0, 0, 3));
        ld(1, mk(1, 0, 8'h11, 0, 0));
        ld(2, mk(5, 0, 0, 0, 8'hFE));
        ld(3, mk(9, 0, 0, 0, 8'h01));
        for (int i = 0; i < 3; i++) expect_wr(0, 8'h11);
        run(8'h01, "R6");
        // R6 zero count: decrement goes negative, no branch
        ld(0, mk(4, 0, 0, 0, 0));
        expect_wr(0, 8'h11);
        run(8'h01, "R6");

        // R7 R8 branch ladder
        ld(0, mk(6, 0, 8'h40, 0, 1));
        ld(1, mk(9, 0, 0, 0, 8'h10));
        ld(2, mk(7, 0, 8'h81, 0, 1));
        ld(3, mk(9, 0, 0, 0, 8'h11));
        ld(4, mk(8, 0, 8'h48, 8'h30, 1));
        ld(5, mk(9, 0, 0, 0, 8'h12));
        ld(6, mk(9, 0, 0, 0, 8'h13));
        regs[1] = 8'h48; run(8'h13, "R8");
        regs[1] = 8'h08; run(8'h10, "R7");
        regs[1] = 8'hC9; run(8'h11, "R7");
        regs[1] = 8'h58; run(8'h12, "R8");
        regs[1] = 8'h40; run(8'h12, "R8");

        // R9 call and return
        ld(0, mk(10, 0, 0, 0, 5));
        ld(1, mk(1, 0, 8'h22, 0, 0));
        ld(2, mk(9, 0, 0, 0, 8'h30));
        ld(5, mk(1, 0, 8'h33, 0, 0));
        ld(6, mk(11, 0, 0, 0, 0));
        expect_wr(0, 8'h33);
        expect_wr(0, 8'h22);
        run(8'h30, "R9");
        // R10 nested call
        ld(6, mk(10, 0, 0, 0, 5));
        expect_wr(0, 8'h33);
        run(8'hFF, "R10");
        // R10 return outside subroutine
        ld(0, mk(11, 0, 0, 0, 0));
        run(8'hFF, "R10");
        // R10 undefined opcode
        ld(0, mk(15, 0, 0, 0, 0));
        run(8'hFF, "R10");
        // R10 reserved bits set
        ld(0, mk(9, 0, 0, 0, 8'h01) | 32'h0100_0000);
        run(8'hFF, "R10");

        // R11 pointer moves
        bmem[8'h20] = 8'hA1; bmem[8'h21] = 8'hB2; bmem[8'h22] = 8'hC3;
        bmem[8'h23] = 8'hEE; bmem[8'h24] = 8'hEE; bmem[8'h25] = 8'hEE;
        regs[2] = 8'h9C;
        ld(0, mk(12, 0, 0, 0, 8'h20));
        ld(1, mk(13, 0, 0, 0, 3));
        ld(2, mk(14, 2, 8'h0F, 0, 2));
        ld(3, mk(13, 0, 0, 0, 0));
        ld(4, mk(9, 0, 0, 0, 8'h40));
        expect_wr(0, 8'hA1); expect_wr(0, 8'hB2); expect_wr(0, 8'hC3);
        run(8'h40, "R11");
        chk(bmem[8'h23] == 8'h0C && bmem[8'h24] == 8'h0C, "R11", "pointer fetch bytes",
            {bmem[8'h23], bmem[8'h24]}, 16'h0C0C);
        chk(bmem[8'h25] == 8'hEE, "R11", "byte past count untouched", bmem[8'h25], 8'hEE);

        // R5 delay of 2 us, with R12 stray start during the wait
        ld(0, mk(1, 0, 8'h01, 0, 0));
        ld(1, mk(3, 0, 0, 0, 2));
        ld(2, mk(1, 0, 8'h02, 0, 0));
        ld(3, mk(9, 0, 0, 0, 8'h50));
        expect_wr(0, 8'h01); expect_wr(0, 8'h02);
        wr_cyc.delete();
        pulse_start();
        repeat (100) @(negedge clk);
        pulse_start();
        wait_done(8'h50, "R12");
        chk(wr_cyc.size() == 2, "R12", "write count", wr_cyc.size(), 2);
        if (wr_cyc.size() == 2)
            chk(wr_cyc[1] - wr_cyc[0] == 252, "R5", "delay spacing", wr_cyc[1] - wr_cyc[0], 252);
        repeat (20) @(negedge clk);
        chk(!busy, "R12", "no restart after done", busy, 0);

        // R5 zero delay
        ld(1, mk(3, 0, 0, 0, 0));
        expect_wr(0, 8'h01); expect_wr(0, 8'h02);
        run(8'h50, "R5");
        if (wr_cyc.size() == 2)
            chk(wr_cyc[1] - wr_cyc[0] == 2, "R5", "zero delay spacing", wr_cyc[1] - wr_cyc[0], 2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule